// File: doc/BRIEF.md
# Multi-Mode Port Status LED Controller

This block turns the per-port line state of a five-port switch (link up, 100 Mb/s speed, full duplex) and its per-port events (transmit activity, receive activity, collision) into four status LED signals per port: a link lamp, an activity lamp, a duplex lamp and a speed lamp. All outputs are active-high "lit" signals. Board drive polarity and any sharing of the pins with strap inputs are handled outside the block.

A 2-bit display mode is sampled on every clock while reset is held and frozen when reset is released. The mode picks one of four meaning maps for the lamps. Short events are stretched into visible blinks by a per-event blink window. After reset, a power-on self-test runs first. During the self-test every lamp of every port blinks in unison through ten timed steps. Normal display starts when the ten steps are done.

The block has no data stream. All pins are plain levels, and the block never pushes back on its inputs.

Top module: `port_led_ctrl`

## Requirements
- R1: `mode_sel` is captured on every clock while `rst_n` is low. Its value is held after release, and later changes of `mode_sel` have no effect. Encoding: 2'b00 = mode 0, 2'b01 = mode 1, 2'b10 = mode 2, 2'b11 = mode 3.
- R2: From reset, every output bit of every port shows the same value for DIAG_STEPS steps of STEP_CYCLES clocks each. The value is lit in even steps (step 0 first) and dark in odd steps, and line and event inputs are ignored. Normal display starts after the last step.
- R3: In modes 0 and 3, `led_link` is dark without link and lit with link while no transmit or receive blink is running. While such a blink runs with link up, it follows the blink.
- R4: In mode 1, `led_link` shows only the receive blink. In mode 2 it shows the blink of transmit or receive activity. In both modes the link state does not gate it.
- R5: In mode 0, `led_act` shows only the collision blink. In mode 1 it is lit when idle and follows the transmit blink while one runs.
- R6: In modes 2 and 3, `led_act` is lit for half duplex and dark for full duplex, and it follows the collision blink while one runs.
- R7: In modes 0 and 3, `led_full` is lit for full duplex. In modes 1 and 2 it is lit for link up.
- R8: In every mode, `led_speed` is lit for 100 Mb/s and dark for 10 Mb/s.
- R9: An event sampled on a clock edge with no blink running starts a blink. The blink is lit for the FLASH_HALF clocks after that edge and dark for the next FLASH_HALF clocks. Any event sampled during a blink adds exactly one further full blink right after the current one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; mode is captured while low |
| mode_sel | input | 2 | Display mode strap value |
| link_up | input | NPORT | Per-port link established |
| speed100 | input | NPORT | Per-port 100 Mb/s (1) or 10 Mb/s (0) |
| full_dup | input | NPORT | Per-port full (1) or half (0) duplex |
| col_ev | input | NPORT | Per-port collision event |
| tx_ev | input | NPORT | Per-port transmit activity event |
| rx_ev | input | NPORT | Per-port receive activity event |
| led_link | output | NPORT | Link lamp per port |
| led_act | output | NPORT | Activity lamp per port |
| led_full | output | NPORT | Duplex lamp per port |
| led_speed | output | NPORT | Speed lamp per port |

## Verification
Line-state inputs pass to the lamps with no clock delay. The bench changes them one time unit after an edge and samples in the same gap between edges. Each event goes into a blink register on the next rising edge, so it shows after that edge, goes dark FLASH_HALF edges later and ends 2*FLASH_HALF edges after the first. The bench counts edges from the cycle it drives each pulse and samples in the lit part, the dark part and after the window. Self-test steps are counted from the first edge after reset release. The bench samples one edge into each step, and 10*STEP_CYCLES edges after release it expects normal display.

// File: rtl/led_pkg.sv
package led_pkg;
  typedef enum logic [1:0] {
    MODE_LA_DUP  = 2'd0,
    MODE_RX_TX   = 2'd1,
    MODE_ANY_LNK = 2'd2,
    MODE_LA_DCOL = 2'd3
  } led_mode_e;

  typedef struct packed {
    logic busy;  // blink window running
    logic lit;   // blink currently in its lit half
  } blink_t;
endpackage

// File: rtl/led_diag_seq.sv
module led_diag_seq #(
  parameter int STEP_CYCLES = 6250000,
  parameter int DIAG_STEPS  = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic diag_active,
  output logic diag_on
);
  localparam int PW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam int SW = $clog2(DIAG_STEPS + 1) + 1;
  localparam logic [PW-1:0] PLAST = PW'(STEP_CYCLES - 1);
  localparam logic [SW-1:0] SLAST = SW'(DIAG_STEPS);

  logic [PW-1:0] pcnt;
  logic [SW-1:0] step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt <= '0;
      step <= '0;
    end else if (step != SLAST) begin
      if (pcnt == PLAST) begin
        pcnt <= '0;
        step <= step + 1'b1;
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

  assign diag_active = (step != SLAST);
  assign diag_on     = ~step[0];

  assert_step_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step <= SLAST);
  assert_diag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !diag_active |=> !diag_active);
endmodule

// File: rtl/led_blink.sv
module led_blink
  import led_pkg::*;
#(
  parameter int FLASH_HALF = 1250000
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ev,
  output blink_t bl
);
  localparam int CW = $clog2(2 * FLASH_HALF);
  localparam logic [CW-1:0] CLAST = CW'(2 * FLASH_HALF - 1);
  localparam logic [CW-1:0] CHALF = CW'(FLASH_HALF);

  logic          busy, pend;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pend <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == '0) begin
        busy <= pend | ev;
        pend <= 1'b0;
        cnt  <= CLAST;
      end else begin
        cnt  <= cnt - 1'b1;
        pend <= pend | ev;
      end
    end else if (ev) begin
      busy <= 1'b1;
      cnt  <= CLAST;
    end
  end

  assign bl.busy = busy;
  assign bl.lit  = busy && (cnt >= CHALF);

  assert_event_opens_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> busy);
  assert_count_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CLAST);
endmodule

// File: rtl/led_port_map.sv
module led_port_map
  import led_pkg::*;
(
  input  led_mode_e mode,
  input  logic      link,
  input  logic      fast,
  input  logic      dup,
  input  blink_t    b_any,
  input  blink_t    b_rx,
  input  blink_t    b_tx,
  input  blink_t    b_col,
  output logic      o_link,
  output logic      o_act,
  output logic      o_full,
  output logic      o_speed
);
  always_comb begin
    o_speed = fast;
    unique case (mode)
      MODE_LA_DUP: begin
        o_link = link & (b_any.busy ? b_any.lit : 1'b1);
        o_act  = b_col.lit;
        o_full = dup;
      end
      MODE_RX_TX: begin
        o_link = b_rx.lit;
        o_act  = b_tx.busy ? b_tx.lit : 1'b1;
        o_full = link;
      end
      MODE_ANY_LNK: begin
        o_link = b_any.lit;
        o_act  = b_col.busy ? b_col.lit : ~dup;
        o_full = link;
      end
      default: begin
        o_link = link & (b_any.busy ? b_any.lit : 1'b1);
        o_act  = b_col.busy ? b_col.lit : ~dup;
        o_full = dup;
      end
    endcase
  end
endmodule

// File: rtl/port_led_ctrl.sv
module port_led_ctrl
  import led_pkg::*;
#(
  parameter int NPORT       = 5,
  parameter int STEP_CYCLES = 6250000,
  parameter int DIAG_STEPS  = 10,
  parameter int FLASH_HALF  = 1250000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic [NPORT-1:0] link_up,
  input  logic [NPORT-1:0] speed100,
  input  logic [NPORT-1:0] full_dup,
  input  logic [NPORT-1:0] col_ev,
  input  logic [NPORT-1:0] tx_ev,
  input  logic [NPORT-1:0] rx_ev,
  output logic [NPORT-1:0] led_link,
  output logic [NPORT-1:0] led_act,
  output logic [NPORT-1:0] led_full,
  output logic [NPORT-1:0] led_speed
);
  localparam int NLAMP = 4 * NPORT;

  led_mode_e        mode_q;
  logic             diag_active, diag_on;
  logic [NPORT-1:0] m_link, m_act, m_full, m_speed;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= led_mode_e'(mode_sel);
  end

  led_diag_seq #(.STEP_CYCLES(STEP_CYCLES), .DIAG_STEPS(DIAG_STEPS)) u_diag (
    .clk(clk), .rst_n(rst_n), .diag_active(diag_active), .diag_on(diag_on)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    blink_t b_any, b_rx, b_tx, b_col;

    led_blink #(.FLASH_HALF(FLASH_HALF)) u_any (
      .clk(clk), .rst_n(rst_n), .ev(tx_ev[p] | rx_ev[p]), .bl(b_any));
    led_blink #(.FLASH_HALF(FLASH_HALF)) u_rx (
      .clk(clk), .rst_n(rst_n), .ev(rx_ev[p]), .bl(b_rx));
    led_blink #(.FLASH_HALF(FLASH_HALF)) u_tx (
      .clk(clk), .rst_n(rst_n), .ev(tx_ev[p]), .bl(b_tx));
    led_blink #(.FLASH_HALF(FLASH_HALF)) u_col (
      .clk(clk), .rst_n(rst_n), .ev(col_ev[p]), .bl(b_col));

    led_port_map u_map (
      .mode(mode_q), .link(link_up[p]), .fast(speed100[p]), .dup(full_dup[p]),
      .b_any(b_any), .b_rx(b_rx), .b_tx(b_tx), .b_col(b_col),
      .o_link(m_link[p]), .o_act(m_act[p]), .o_full(m_full[p]),
      .o_speed(m_speed[p]));
  end

  always_comb begin
    if (diag_active) begin
      led_link  = {NPORT{diag_on}};
      led_act   = {NPORT{diag_on}};
      led_full  = {NPORT{diag_on}};
      led_speed = {NPORT{diag_on}};
    end else begin
      led_link  = m_link;
      led_act   = m_act;
      led_full  = m_full;
      led_speed = m_speed;
    end
  end

  assert_mode_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));
  assert_diag_uniform_R2: assert property (@(posedge clk) disable iff (!rst_n)
    diag_active |->
      ($countones({led_link, led_act, led_full, led_speed}) == 0 ||
       $countones({led_link, led_act, led_full, led_speed}) == NLAMP));
  assert_link_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!diag_active && (mode_q == MODE_LA_DUP || mode_q == MODE_LA_DCOL))
      |-> ((led_link & ~link_up) == '0));
endmodule

// File: tb/port_led_ctrl_test.sv
module port_led_ctrl_test;
  localparam int NP = 5;
  localparam int ST = 4;
  localparam int DS = 10;
  localparam int FH = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode_sel = 2'b11;
  logic [NP-1:0] link_up = '0, speed100 = '0, full_dup = '0;
  logic [NP-1:0] col_ev = '0, tx_ev = '0, rx_ev = '0;
  logic [NP-1:0] led_link, led_act, led_full, led_speed;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  port_led_ctrl #(.NPORT(NP), .STEP_CYCLES(ST), .DIAG_STEPS(DS), .FLASH_HALF(FH)) uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .link_up(link_up),
    .speed100(speed100), .full_dup(full_dup), .col_ev(col_ev), .tx_ev(tx_ev),
    .rx_ev(rx_ev), .led_link(led_link), .led_act(led_act), .led_full(led_full),
    .led_speed(led_speed));

  // mode, link, speed, duplex, expected link, act, full, speed
  localparam logic [36:0] VEC [8] = '{
    {2'd0, 5'b10110, 5'b01101, 5'b11010, 5'b10110, 5'b00000, 5'b11010, 5'b01101},
    {2'd0, 5'b01011, 5'b10010, 5'b00111, 5'b01011, 5'b00000, 5'b00111, 5'b10010},
    {2'd1, 5'b10110, 5'b01101, 5'b11010, 5'b00000, 5'b11111, 5'b10110, 5'b01101},
    {2'd1, 5'b01011, 5'b10010, 5'b00111, 5'b00000, 5'b11111, 5'b01011, 5'b10010},
    {2'd2, 5'b10110, 5'b01101, 5'b11010, 5'b00000, 5'b00101, 5'b10110, 5'b01101},
    {2'd2, 5'b01011, 5'b10010, 5'b00111, 5'b00000, 5'b11000, 5'b01011, 5'b10010},
    {2'd3, 5'b10110, 5'b01101, 5'b11010, 5'b10110, 5'b00101, 5'b11010, 5'b01101},
    {2'd3, 5'b01011, 5'b10010, 5'b00111, 5'b01011, 5'b11000, 5'b00111, 5'b10010}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] lamps();
    return {led_link, led_act, led_full, led_speed};
  endfunction

  // reset with a mode; optionally check each self-test step (R2)
  task automatic do_reset(input logic [1:0] m, input bit check_diag);
    rst_n = 1'b0;
    mode_sel = m;
    tick(3);
    if (check_diag) chk("R2 reset state", lamps(), '1);
    rst_n = 1'b1;
    tick(1);
    for (int k = 0; k < DS; k++) begin
      if (check_diag) chk("R2 self-test step", lamps(), (k % 2 == 0) ? '1 : '0);
      tick((k == DS - 1) ? ST - 1 : ST);
    end
  endtask

  initial begin
    #(200000 * 4);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [1:0] cur;
    #1;
    link_up = '1; speed100 = '1; full_dup = 5'b01010; tx_ev = 5'b00100;
    do_reset(2'd3, 1'b1);
    tx_ev = '0;
    tick(2 * FH + 1);

    // table walk: static maps of every mode (R3 R4 R5 R6 R7 R8)
    cur = 2'd3;
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][36:35] != cur) begin
        cur = VEC[i][36:35];
        do_reset(cur, 1'b0);
      end
      link_up = VEC[i][34:30]; speed100 = VEC[i][29:25]; full_dup = VEC[i][24:20];
      #1;
      chk("R3 R4 link map", {15'd0, led_link}, {15'd0, VEC[i][19:15]});
      chk("R5 R6 act map", {15'd0, led_act}, {15'd0, VEC[i][14:10]});
      chk("R7 full map", {15'd0, led_full}, {15'd0, VEC[i][9:5]});
      chk("R8 speed map", {15'd0, led_speed}, {15'd0, VEC[i][4:0]});
      tick(1);
    end

    // mode 3, still latched; mode_sel change after reset ignored (R1)
    mode_sel = 2'b01;
    link_up = 5'b00001; full_dup = 5'b00000;
    tick(1);
    chk("R1 mode held", {15'd0, led_full}, 20'd0);

    // single blink on link lamp (R3 R9)
    tx_ev[0] = 1'b1; tick(1); tx_ev[0] = 1'b0;
    chk("R9 blink lit half", {19'd0, led_link[0]}, 20'd1);
    tick(3);
    chk("R3 blink dark half", {19'd0, led_link[0]}, 20'd0);
    tick(3);
    chk("R3 steady after blink", {19'd0, led_link[0]}, 20'd1);

    // event during the dark half adds a blink (R9)
    rx_ev[0] = 1'b1; tick(1); rx_ev[0] = 1'b0;
    tick(3);
    rx_ev[0] = 1'b1; tick(1); rx_ev[0] = 1'b0;
    tick(5);
    chk("R9 extended blink dark", {19'd0, led_link[0]}, 20'd0);
    tick(3);
    chk("R9 extension ends", {19'd0, led_link[0]}, 20'd1);

    // activity without link stays dark (R3)
    tx_ev[1] = 1'b1; tick(1); tx_ev[1] = 1'b0;
    chk("R3 no link dark", {19'd0, led_link[1]}, 20'd0);
    tick(6);

    // collision blink over half and full duplex (R6)
    full_dup = 5'b00010;
    col_ev[1:0] = 2'b11; tick(1); col_ev[1:0] = 2'b00;
    chk("R6 col lit", {18'd0, led_act[1:0]}, 20'b11);
    tick(3);
    chk("R6 col dark", {18'd0, led_act[1:0]}, 20'b00);
    tick(3);
    chk("R6 half/full after col", {18'd0, led_act[1:0]}, 20'b01);

    // mode 1: rx-only link lamp, tx blink on act lamp (R4 R5)
    link_up = '1; full_dup = '0;
    do_reset(2'd1, 1'b0);
    tx_ev[2] = 1'b1; rx_ev[3] = 1'b1; tick(1); tx_ev[2] = 1'b0; rx_ev[3] = 1'b0;
    chk("R4 rx only link", {15'd0, led_link}, {15'd0, 5'b01000});
    tick(3);
    chk("R5 tx blink dark", {15'd0, led_act}, {15'd0, 5'b11011});
    tick(3);

    // mode 2: tx blink on link lamp (R4); mode 0: col on act (R5)
    do_reset(2'd2, 1'b0);
    tx_ev[4] = 1'b1; tick(1); tx_ev[4] = 1'b0;
    chk("R4 any activity link", {15'd0, led_link}, {15'd0, 5'b10000});
    do_reset(2'd0, 1'b0);
    col_ev[2] = 1'b1; tick(1); col_ev[2] = 1'b0;
    chk("R5 col only act", {15'd0, led_act}, {15'd0, 5'b00100});

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule